// File: doc/BRIEF.md
# Trigger Busy Generator

This block drives one BUSY line toward the trigger system. BUSY is the OR of four causes: the timing receiver reports not ready, a hold-off timer started by each L0 trigger is still running, the trigger receiver is partway through decoding a sequence, and the number of outstanding event buffers has reached a programmable limit. Each cause is also shown as its own flag in a status word, so the host can tell why the line is high.

The hold-off length is set in a 16-bit host register in units of 10 us. A prescaler divides the 25 ns clock by 400 to make that unit. Every L0 trigger reloads the timer and restarts the prescaler. The outstanding-buffer count goes up on each L0 trigger and down on each buffer-release pulse. A counter records how many clock cycles BUSY has been high. The host reads that counter as two 16-bit halves through a small register port that has four word addresses.

Top module: `trig_busy_gen`

## Requirements
- R1: `busy_o` is high exactly when at least one cause is active: `timing_ready_i` low, the hold-off timer running, `seq_active_i` high, or the buffers full.
- R2: An L0 trigger with a non-zero timeout T starts the hold-off (status bit 13) at the clock edge that samples it. The hold-off ends exactly 400*T edges later. A new L0 trigger reloads T and restarts the prescaler. A timeout of 0 never starts the hold-off.
- R3: The status word (address 1) has these bits: bit 15 = timing receiver not ready, bit 14 = buffers full, bit 13 = hold-off running, bit 12 = sequence in progress. Bits 11:8 always read 0.
- R4: The outstanding-buffer count is shown in status bits 7:4. It rises by 1 on an L0 trigger and falls by 1 on a release pulse. It stays unchanged when both arrive in the same cycle. It holds at 0 on a release and at 15 on a trigger.
- R5: The buffers are full when the count is greater than or equal to the limit in status bits 3:0. BUSY stays high while the buffers are full, even after the hold-off has ended.
- R6: The busy-time counter adds 1 for each clock edge at which `busy_o` was high. Its bits 31:16 read at address 2 and bits 15:0 read at address 3. It saturates at its maximum value.
- R7: Address 0 is the read/write timeout register. A write to address 1 stores only bits 3:0, as the limit. Writes to addresses 2 and 3 have no effect.
- R8: While reset is held, the timeout reads 10, the limit and the buffer count read 0, and the busy-time counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz clock (25 ns) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timing_ready_i | input | 1 | Timing receiver ready |
| l0_trig_i | input | 1 | L0 trigger pulse, one cycle |
| seq_active_i | input | 1 | Trigger receiver decoding a sequence |
| buf_release_i | input | 1 | One event buffer freed, one cycle |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | 2 | Host word address |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data, combinational from address |
| busy_o | output | 1 | BUSY to the trigger system |

## Verification
The checker assumes that `l0_trig_i` and `buf_release_i` are single-cycle pulses sampled on rising edges. It also assumes that the host port is driven only from the same clock domain. The buffer-step property relies on the count moving by at most one per edge. The time-step properties start one cycle after reset is released, so reset-time values are never compared. The bench changes every input on falling edges and holds each pulse for exactly one cycle. It reads back through the register port only in the settled half of the cycle, and it waits for the hold-off to end before measuring the busy time.

// File: rtl/busy_pkg.sv
package busy_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned TOUT_W = 16;
  localparam int unsigned BUF_W  = 4;

  typedef enum logic [1:0] {
    ADDR_TIMEOUT = 2'd0,
    ADDR_STATUS  = 2'd1,
    ADDR_TIME_HI = 2'd2,
    ADDR_TIME_LO = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_NOT_READY = 15;
  localparam int unsigned ST_FULL      = 14;
  localparam int unsigned ST_HOLDOFF   = 13;
  localparam int unsigned ST_SEQ       = 12;
  localparam int unsigned ST_COUNT_LSB = 4;
  localparam int unsigned ST_LIMIT_LSB = 0;
endpackage

// File: rtl/busy_prescaler.sv
module busy_prescaler #(
  parameter int unsigned DIV = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/busy_holdoff.sv
module busy_holdoff #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         tick_i,
  input  logic [W-1:0] timeout_i,
  output logic         active_o
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rem_q <= '0;
    else if (load_i)                rem_q <= timeout_i;
    else if (tick_i && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign active_o = (rem_q != '0);
endmodule

// File: rtl/busy_buf_count.sv
module busy_buf_count #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] count_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign count_o = cnt_q;
  assign full_o  = (cnt_q >= limit_i);
endmodule

// File: rtl/busy_time_acc.sv
module busy_time_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (en_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/trig_busy_gen.sv
module trig_busy_gen
  import busy_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 400,
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned TIMEOUT_RST = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             timing_ready_i,
  input  logic             l0_trig_i,
  input  logic             seq_active_i,
  input  logic             buf_release_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             busy_o
);
  logic [TOUT_W-1:0] timeout_q;
  logic [BUF_W-1:0]  limit_q;
  logic              tick, hold_active, buf_full;
  logic [BUF_W-1:0]  buf_count;
  logic [TIME_W-1:0] busy_time;
  logic [31:0]       time_ext;
  logic [REG_W-1:0]  status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= TOUT_W'(TIMEOUT_RST);
      limit_q   <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == ADDR_TIMEOUT) timeout_q <= reg_wdata_i[TOUT_W-1:0];
      if (reg_addr_i == ADDR_STATUS)  limit_q   <= reg_wdata_i[ST_LIMIT_LSB +: BUF_W];
    end
  end

  busy_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i, .rst_ni, .restart_i(l0_trig_i), .tick_o(tick)
  );

  busy_holdoff #(.W(TOUT_W)) u_hold (
    .clk_i, .rst_ni, .load_i(l0_trig_i), .tick_i(tick),
    .timeout_i(timeout_q), .active_o(hold_active)
  );

  busy_buf_count #(.W(BUF_W)) u_bufs (
    .clk_i, .rst_ni, .inc_i(l0_trig_i), .dec_i(buf_release_i),
    .limit_i(limit_q), .count_o(buf_count), .full_o(buf_full)
  );

  assign busy_o = !timing_ready_i || hold_active || seq_active_i || buf_full;

  busy_time_acc #(.W(TIME_W)) u_time (
    .clk_i, .rst_ni, .en_i(busy_o), .count_o(busy_time)
  );

  always_comb begin
    time_ext = '0;
    time_ext[TIME_W-1:0] = busy_time;
  end

  always_comb begin
    status = '0;
    status[ST_NOT_READY] = !timing_ready_i;
    status[ST_FULL]      = buf_full;
    status[ST_HOLDOFF]   = hold_active;
    status[ST_SEQ]       = seq_active_i;
    status[ST_COUNT_LSB +: BUF_W] = buf_count;
    status[ST_LIMIT_LSB +: BUF_W] = limit_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_TIMEOUT: reg_rdata_o = REG_W'(timeout_q);
      ADDR_STATUS:  reg_rdata_o = status;
      ADDR_TIME_HI: reg_rdata_o = time_ext[31:16];
      default:      reg_rdata_o = time_ext[15:0];
    endcase
  end
endmodule

// File: rtl/busy_chk.sv
module busy_chk #(
  parameter int unsigned TIME_W = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        timing_ready_i,
  input logic        l0_trig_i,
  input logic        seq_active_i,
  input logic        busy_o,
  input logic [15:0] timeout_i,
  input logic [15:0] status_i,
  input logic [31:0] busy_time_i
);
  localparam logic [31:0] TIME_MAX = 32'((64'd1 << TIME_W) - 64'd1);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1: no cause means no busy
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timing_ready_i && !seq_active_i && !status_i[14] && !status_i[13]) |-> !busy_o);

  p_hold_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l0_trig_i && timeout_i != 16'd0) |=> status_i[13]);

  p_not_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !timing_ready_i |-> (status_i[15] && busy_o));

  p_unused_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[11:8] == 4'd0);

  p_buf_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (status_i[7:4] == $past(status_i[7:4])) ||
                (status_i[7:4] == $past(status_i[7:4]) + 4'd1) ||
                ($past(status_i[7:4]) == status_i[7:4] + 4'd1));

  p_full_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[14] |-> busy_o);

  p_time_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(busy_o) && $past(busy_time_i) != TIME_MAX)
      |-> busy_time_i == $past(busy_time_i) + 32'd1);

  p_time_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && (!$past(busy_o) || $past(busy_time_i) == TIME_MAX)) |-> $stable(busy_time_i));
endmodule

bind trig_busy_gen busy_chk #(.TIME_W(TIME_W)) u_chk (
  .clk_i, .rst_ni, .timing_ready_i, .l0_trig_i, .seq_active_i, .busy_o,
  .timeout_i(16'(timeout_q)), .status_i(status), .busy_time_i(time_ext)
);

// File: tb/trig_busy_gen_tb.sv
module trig_busy_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ready = 1'b0, l0 = 1'b0, seq = 1'b0, rel = 1'b0;
  logic wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = '0, rdata;
  logic busy;
  logic [15:0] sat_rdata;
  logic sat_busy;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_busy_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .timing_ready_i(ready), .l0_trig_i(l0),
    .seq_active_i(seq), .buf_release_i(rel), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy)
  );

  // small counter to reach saturation; never ready, so always busy
  trig_busy_gen #(.TICK_DIV(4), .TIME_W(6)) u_sat (
    .clk_i(clk), .rst_ni(rst_n), .timing_ready_i(1'b0), .l0_trig_i(1'b0),
    .seq_active_i(1'b0), .buf_release_i(1'b0), .reg_wr_i(1'b0), .reg_addr_i(2'd3),
    .reg_wdata_i(16'd0), .reg_rdata_o(sat_rdata), .busy_o(sat_busy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_l0();
    @(negedge clk); l0 = 1'b1;
    @(negedge clk); l0 = 1'b0;
  endtask

  task automatic pulse_rel();
    @(negedge clk); rel = 1'b1;
    @(negedge clk); rel = 1'b0;
  endtask

  task automatic read_time(output logic [31:0] t);
    logic [15:0] h, l;
    rd(2'd2, h); rd(2'd3, l); t = {h, l};
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R8 timeout reset", d, 16'd10);
    rd(2'd1, d); check("R8 status reset", d, 16'hC000);
    rd(2'd2, d); check("R8 time hi reset", d, 16'd0);
    rd(2'd3, d); check("R8 time lo reset", d, 16'd0);
    check("R1 busy in reset", busy, 1'b1);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    logic [31:0] t0, t1;
    @(negedge clk); ready = 1'b1;
    wr_reg(2'd1, 16'hFFFF);
    rd(2'd1, d); check("R7 limit only, R3 unused zero", d, 16'h000F);
    check("R1 idle", busy, 1'b0);
    wr_reg(2'd0, 16'd3);
    rd(2'd0, d); check("R7 timeout rw", d, 16'd3);
    read_time(t0);
    wr_reg(2'd2, 16'h1234);
    wr_reg(2'd3, 16'h5678);
    read_time(t1); check("R7 time writes ignored", t1, t0);
  endtask

  task automatic t_causes();
    logic [15:0] d;
    @(negedge clk); ready = 1'b0; #1;
    rd(2'd1, d); check("R3 not ready bit", d[15], 1'b1);
    check("R1 busy not ready", busy, 1'b1);
    @(negedge clk); ready = 1'b1; seq = 1'b1; #1;
    rd(2'd1, d); check("R3 seq bit", d[15:12], 4'b0001);
    check("R1 busy seq", busy, 1'b1);
    @(negedge clk); seq = 1'b0; #1;
    check("R1 idle again", busy, 1'b0);
  endtask

  task automatic t_holdoff();
    logic [15:0] d;
    wr_reg(2'd0, 16'd2);
    pulse_l0();
    repeat (2*DIV - 1) @(negedge clk);
    rd(2'd1, d); check("R2 holdoff last cycle", d[13], 1'b1);
    check("R1 busy holdoff", busy, 1'b1);
    @(negedge clk);
    rd(2'd1, d); check("R2 holdoff ended", d[13], 1'b0);
    check("R1 busy after holdoff", busy, 1'b0);
    // retrigger restarts the full window
    pulse_l0();
    repeat (500) @(negedge clk);
    pulse_l0();
    repeat (2*DIV - 1) @(negedge clk);
    rd(2'd1, d); check("R2 retrigger still on", d[13], 1'b1);
    @(negedge clk);
    rd(2'd1, d); check("R2 retrigger ended", d[13], 1'b0);
    check("R4 count after 3 triggers", d[7:4], 4'd3);
    repeat (3) pulse_rel();
    wr_reg(2'd0, 16'd0);
    pulse_l0();
    rd(2'd1, d); check("R2 zero timeout no holdoff", d[13], 1'b0);
    pulse_rel();
  endtask

  task automatic t_buffers();
    logic [15:0] d;
    wr_reg(2'd1, 16'd2);
    pulse_rel();
    rd(2'd1, d); check("R4 release at zero holds", d[7:4], 4'd0);
    pulse_l0(); pulse_l0();
    rd(2'd1, d); check("R5 full at limit", d[15:12], 4'b0100);
    check("R4 count two", d[7:4], 4'd2);
    check("R5 busy full", busy, 1'b1);
    @(negedge clk); l0 = 1'b1; rel = 1'b1;
    @(negedge clk); l0 = 1'b0; rel = 1'b0;
    rd(2'd1, d); check("R4 both same cycle", d[7:4], 4'd2);
    pulse_rel();
    rd(2'd1, d); check("R5 below limit", d[14], 1'b0);
    check("R1 busy cleared", busy, 1'b0);
    pulse_rel();
    wr_reg(2'd1, 16'd15);
    repeat (17) pulse_l0();
    rd(2'd1, d); check("R4 saturate at 15", d[7:4], 4'd15);
    repeat (15) pulse_rel();
    rd(2'd1, d); check("R4 back to zero", d[7:4], 4'd0);
    // full outlasts holdoff
    wr_reg(2'd0, 16'd1);
    wr_reg(2'd1, 16'd1);
    pulse_l0();
    repeat (DIV + 1) @(negedge clk);
    rd(2'd1, d); check("R5 full after holdoff", d, 16'h4011);
    check("R5 busy held by full", busy, 1'b1);
    pulse_rel();
    check("R5 released", busy, 1'b0);
  endtask

  task automatic t_time();
    logic [31:0] t0, t1;
    read_time(t0);
    @(negedge clk); seq = 1'b1;
    repeat (37) @(negedge clk);
    seq = 1'b0;
    read_time(t1); check("R6 busy cycles counted", t1 - t0, 32'd37);
    repeat (5) @(negedge clk);
    read_time(t0); check("R6 stable when idle", t0, t1);
    #1; check("R6 saturates", {16'd0, sat_rdata}, 32'd63);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_regs();
    t_causes();
    t_holdoff();
    t_buffers();
    t_time();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule